// File: doc/BRIEF.md
# Three-Wire Addressed Configuration Port

This block receives configuration words over a write-only three-wire serial link and holds them in four addressed registers that drive a frequency synthesiser and a test-routing network. A host shifts an 18-bit frame on the serial data line, one bit per rising edge of the serial clock, with the most significant bit first. The first two bits select the register and the remaining sixteen carry its contents. A rising edge on the latch line commits the most recent 18 bits. All three serial lines, and the enable line, are brought into the system clock domain through multi-flop synchronisers. The edges are then detected in that domain, so serial pulses only need to span a few system clocks.

The enable input separates active operation from power-save. Each low-to-high transition of enable reloads every field from a preset. The preset is chosen by the static levels that the host straps onto the three serial lines at that moment, so common reference and IF combinations need no serial traffic at all. Register contents survive power-save untouched. Two addresses share one layout: both write the main divide value and the clock-output enable. Test-route codes that name no route are stored as the normal-operation code.

Top module: `cfg3w_port`

## Requirements
- R1: A frame is the last 18 bits sampled on rising serial-clock edges before a rising latch edge, first bit most significant: frame[17:16] is the address and frame[15:0] the data D15..D0. Any bits shifted earlier than those 18 are discarded.
- R2: A frame with address 2'b00 sets the 11-bit main divide to D15..D5 and the clock-output enable to D1 (1 = clock output on).
- R3: Address 2'b11 behaves exactly like address 2'b00 and writes the same two fields.
- R4: Address 2'b01 sets the 5-bit swallow value to D15..D11, the 9-bit reference divide to D10..D2 and the test enable to D0.
- R5: Address 2'b10 sets the 3-bit test-input select to D15..D13, the 3-bit test-output select to D12..D10 and the filter select to D1 (0 = normal low-pass).
- R6: A test-select code of 3'b011 or 3'b100 written through address 2'b10 is stored as 3'b000.
- R7: A latched frame changes only the fields that belong to its address, and all other fields keep their values.
- R8: On a rising enable with straps DATA=1, CLK=0, LT=0, the block loads main divide 21, swallow 9 and reference divide 3, and clears every other field.
- R9: On a rising enable with straps DATA=1, CLK=1, LT=0, the block loads main divide 50, swallow 11 and reference divide 5, and clears every other field.
- R10: On a rising enable with any other strap combination, including the reserved all-zero one, every field is cleared.
- R11: The active output follows enable (0 = power-save). A falling enable leaves every field unchanged.
- R12: Serial clock edges with no latch edge do not change any field.
- R13: After reset every field is 0 and the active output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enable: 1 active, 0 power-save; its rising edge loads a preset |
| ser_dat_i | input | 1 | Serial data, also a strap at enable rise |
| ser_clk_i | input | 1 | Serial clock, sampled on its rising edge; also a strap |
| ser_lat_i | input | 1 | Latch strobe, commits on its rising edge; also a strap |
| active_o | output | 1 | Synchronised enable level |
| main_div_o | output | 11 | Main divide value |
| swal_o | output | 5 | Swallow value |
| ref_div_o | output | 9 | Reference divide value |
| ckout_en_o | output | 1 | Reference clock output enable |
| filt_sel_o | output | 1 | Filter select |
| test_en_o | output | 1 | Test path enable |
| tin_sel_o | output | 3 | Test-input route select |
| tout_sel_o | output | 3 | Test-output route select |

## Verification
Directed frames go to each of the four addresses with distinctive bit patterns. Each pattern shows whether a field lands in its own bit positions, and whether the alias address and the neighbouring registers are left intact. Frames with extra leading bits separate a correct "last 18 bits" window from one anchored at the start of transfer. Illegal test codes separate the forced-zero rule from plain storage. Every strap combination that matters is applied at an enable rise, mixed with power-save periods, to tell a preset load apart from plain retention. A fixed-seed random run of addresses, data words and leading-bit counts is then compared against a bench model.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;
   localparam int ADDR_W  = 2;
   localparam int DATA_W  = 16;
   localparam int FRAME_W = ADDR_W + DATA_W;
   localparam int MAIN_W  = 11;
   localparam int SWAL_W  = 5;
   localparam int REF_W   = 9;
   localparam int TSEL_W  = 3;

   typedef enum logic [ADDR_W-1:0] {
      ADR_MAIN     = 2'b00,
      ADR_DIV      = 2'b01,
      ADR_TEST     = 2'b10,
      ADR_MAIN_ALT = 2'b11
   } adr_e;

   typedef struct packed {
      logic [MAIN_W-1:0] main_div;
      logic [SWAL_W-1:0] swal;
      logic [REF_W-1:0]  ref_div;
      logic              ckout_en;
      logic              filt_sel;
      logic              test_en;
      logic [TSEL_W-1:0] tin_sel;
      logic [TSEL_W-1:0] tout_sel;
   } cfg_t;

   // strap order: {data, clock, latch}
   localparam logic [2:0] STRAP_A = 3'b100;
   localparam logic [2:0] STRAP_B = 3'b110;

   function automatic logic [TSEL_W-1:0] tsel_fix(input logic [TSEL_W-1:0] code);
      return (code == 3'b011 || code == 3'b100) ? '0 : code;
   endfunction
endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] st_q [STAGES];

   initial begin
      assert (STAGES >= 2) else $error("cfg3w_sync: STAGES must be at least 2");
      assert (W >= 1) else $error("cfg3w_sync: W must be positive");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
      end else begin
         st_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
      end
   end

   assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/cfg3w_shift.sv
module cfg3w_shift #(
   parameter int FW = 18
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          shift_i,
   input  logic          bit_i,
   output logic [FW-1:0] frame_o
);
   logic [FW-1:0] sr_q;

   initial begin
      assert (FW >= 4) else $error("cfg3w_shift: FW too small");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sr_q <= '0;
      else if (shift_i) sr_q <= {sr_q[FW-2:0], bit_i};
   end

   assign frame_o = sr_q;

   // R1: newest bit enters at the bottom, older bits move up
   p_shift_order_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shift_i |=> (frame_o[0] == $past(bit_i)) && (frame_o[FW-1:1] == $past(frame_o[FW-2:0])));

   // R12: no serial edge, window frozen
   p_shift_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !shift_i |=> $stable(frame_o));
endmodule

// File: rtl/cfg3w_regs.sv
module cfg3w_regs
   import cfg3w_pkg::*;
#(
   parameter logic [MAIN_W-1:0] PA_MAIN = 11'd21,
   parameter logic [SWAL_W-1:0] PA_SWAL = 5'd9,
   parameter logic [REF_W-1:0]  PA_REF  = 9'd3,
   parameter logic [MAIN_W-1:0] PB_MAIN = 11'd50,
   parameter logic [SWAL_W-1:0] PB_SWAL = 5'd11,
   parameter logic [REF_W-1:0]  PB_REF  = 9'd5
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               lat_i,
   input  logic               init_i,
   input  logic [2:0]         strap_i,
   input  logic [FRAME_W-1:0] frame_i,
   output cfg_t               cfg_o
);
   cfg_t cfg_q, cfg_d, preset;
   logic [ADDR_W-1:0] adr;
   logic [DATA_W-1:0] dat;

   assign adr = frame_i[FRAME_W-1:DATA_W];
   assign dat = frame_i[DATA_W-1:0];

   always_comb begin
      preset = '0;
      case (strap_i)
         STRAP_A: begin
            preset.main_div = PA_MAIN;
            preset.swal     = PA_SWAL;
            preset.ref_div  = PA_REF;
         end
         STRAP_B: begin
            preset.main_div = PB_MAIN;
            preset.swal     = PB_SWAL;
            preset.ref_div  = PB_REF;
         end
         default: preset = '0;
      endcase
   end

   always_comb begin
      cfg_d = cfg_q;
      if (init_i) begin
         cfg_d = preset;
      end else if (lat_i) begin
         case (adr)
            ADR_MAIN, ADR_MAIN_ALT: begin
               cfg_d.main_div = dat[15:5];
               cfg_d.ckout_en = dat[1];
            end
            ADR_DIV: begin
               cfg_d.swal    = dat[15:11];
               cfg_d.ref_div = dat[10:2];
               cfg_d.test_en = dat[0];
            end
            default: begin
               cfg_d.tin_sel  = tsel_fix(dat[15:13]);
               cfg_d.tout_sel = tsel_fix(dat[12:10]);
               cfg_d.filt_sel = dat[1];
            end
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q <= '0;
      else         cfg_q <= cfg_d;
   end

   assign cfg_o = cfg_q;

   // R12: without a strobe or enable edge nothing moves
   p_regs_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lat_i && !init_i) |=> $stable(cfg_q));

   // R3: alias address writes the main divide field
   p_alias_main_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lat_i && !init_i && frame_i[17:16] == 2'b11) |=> cfg_q.main_div == $past(frame_i[15:5]));

   // R7: a divider-register write leaves main and test fields alone
   p_div_isolated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lat_i && !init_i && frame_i[17:16] == 2'b01) |=>
         $stable(cfg_q.main_div) && $stable(cfg_q.tin_sel) && $stable(cfg_q.tout_sel));

   // R8: first preset
   p_preset_a_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (init_i && strap_i == 3'b100) |=>
         cfg_q.main_div == PA_MAIN && cfg_q.swal == PA_SWAL && cfg_q.ref_div == PA_REF);

   // R6: unused route codes never held
   p_tsel_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_q.tin_sel != 3'b011 && cfg_q.tin_sel != 3'b100 &&
      cfg_q.tout_sel != 3'b011 && cfg_q.tout_sel != 3'b100);
endmodule

// File: rtl/cfg3w_port.sv
module cfg3w_port
   import cfg3w_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              ser_dat_i,
   input  logic              ser_clk_i,
   input  logic              ser_lat_i,
   output logic              active_o,
   output logic [MAIN_W-1:0] main_div_o,
   output logic [SWAL_W-1:0] swal_o,
   output logic [REF_W-1:0]  ref_div_o,
   output logic              ckout_en_o,
   output logic              filt_sel_o,
   output logic              test_en_o,
   output logic [TSEL_W-1:0] tin_sel_o,
   output logic [TSEL_W-1:0] tout_sel_o
);
   localparam int NSIG = 4;

   logic [NSIG-1:0] raw, syn;
   logic            en_s, dat_s, sck_s, lat_s;
   logic            en_p_q, sck_p_q, lat_p_q;
   logic            en_rise, sck_rise, lat_rise;
   logic [FRAME_W-1:0] frame;
   cfg_t            cfg;

   assign raw = {en_i, ser_lat_i, ser_clk_i, ser_dat_i};

   cfg3w_sync #(.STAGES(SYNC_STAGES), .W(NSIG)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw),
      .q_o   (syn)
   );

   assign {en_s, lat_s, sck_s, dat_s} = syn;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_p_q  <= 1'b0;
         sck_p_q <= 1'b0;
         lat_p_q <= 1'b0;
      end else begin
         en_p_q  <= en_s;
         sck_p_q <= sck_s;
         lat_p_q <= lat_s;
      end
   end

   assign en_rise  = en_s  & ~en_p_q;
   assign sck_rise = sck_s & ~sck_p_q;
   assign lat_rise = lat_s & ~lat_p_q;

   cfg3w_shift #(.FW(FRAME_W)) u_shift (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .shift_i(sck_rise),
      .bit_i  (dat_s),
      .frame_o(frame)
   );

   cfg3w_regs u_regs (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lat_i  (lat_rise),
      .init_i (en_rise),
      .strap_i({dat_s, sck_s, lat_s}),
      .frame_i(frame),
      .cfg_o  (cfg)
   );

   assign active_o   = en_s;
   assign main_div_o = cfg.main_div;
   assign swal_o     = cfg.swal;
   assign ref_div_o  = cfg.ref_div;
   assign ckout_en_o = cfg.ckout_en;
   assign filt_sel_o = cfg.filt_sel;
   assign test_en_o  = cfg.test_en;
   assign tin_sel_o  = cfg.tin_sel;
   assign tout_sel_o = cfg.tout_sel;

   // R11: falling enable never disturbs stored fields
   p_save_keeps_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(active_o) && !lat_rise) |=> $stable(main_div_o) && $stable(ref_div_o) && $stable(tin_sel_o));
endmodule

// File: tb/sim_cfg3w_port.sv
module sim_cfg3w_port;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, sdat = 1'b0, sclk = 1'b0, slat = 1'b0;
   logic act;
   logic [10:0] main_div;
   logic [4:0]  swal;
   logic [8:0]  ref_div;
   logic ck_en, filt, ten;
   logic [2:0] tin, tout;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // expected model
   logic [10:0] e_main;
   logic [4:0]  e_swal;
   logic [8:0]  e_ref;
   logic e_ck, e_filt, e_ten;
   logic [2:0] e_tin, e_tout;

   always #10 clk = ~clk;

   cfg3w_port u0 (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en),
      .ser_dat_i(sdat), .ser_clk_i(sclk), .ser_lat_i(slat),
      .active_o(act), .main_div_o(main_div), .swal_o(swal), .ref_div_o(ref_div),
      .ckout_en_o(ck_en), .filt_sel_o(filt), .test_en_o(ten),
      .tin_sel_o(tin), .tout_sel_o(tout)
   );

   function automatic logic [2:0] legal_code(input logic [2:0] c);
      if (c == 3'd3 || c == 3'd4) return 3'd0;
      return c;
   endfunction

   function automatic logic [33:0] pack_exp();
      return {e_main, e_swal, e_ref, e_ck, e_filt, e_ten, e_tin, e_tout};
   endfunction

   task automatic clear_exp();
      e_main = '0; e_swal = '0; e_ref = '0;
      e_ck = 0; e_filt = 0; e_ten = 0; e_tin = '0; e_tout = '0;
   endtask

   task automatic model_write(input logic [1:0] a, input logic [15:0] d);
      case (a)
         2'b00, 2'b11: begin e_main = d[15:5]; e_ck = d[1]; end
         2'b01: begin e_swal = d[15:11]; e_ref = d[10:2]; e_ten = d[0]; end
         default: begin e_tin = legal_code(d[15:13]); e_tout = legal_code(d[12:10]); e_filt = d[1]; end
      endcase
   endtask

   task automatic check(input string req, input logic [33:0] got, input logic [33:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic check_fields(input string req);
      @(negedge clk);
      check(req, {main_div, swal, ref_div, ck_en, filt, ten, tin, tout}, pack_exp());
   endtask

   task automatic check_act(input string req, input logic exp);
      @(negedge clk);
      check(req, {33'd0, act}, {33'd0, exp});
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk); sdat = b;
      repeat (3) @(negedge clk); sclk = 1'b1;
      repeat (3) @(negedge clk); sclk = 1'b0;
   endtask

   task automatic strobe();
      repeat (3) @(negedge clk); slat = 1'b1;
      repeat (3) @(negedge clk); slat = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic send_frame(input logic [1:0] a, input logic [15:0] d, input int nlead);
      logic [17:0] f;
      f = {a, d};
      for (int i = 0; i < nlead; i++) send_bit(1'($urandom_range(0, 1)));
      for (int i = 17; i >= 0; i--) send_bit(f[i]);
      strobe();
      model_write(a, d);
   endtask

   task automatic power_up(input logic [2:0] strap);
      @(negedge clk);
      en = 1'b0;
      repeat (6) @(negedge clk);
      {sdat, sclk, slat} = strap;
      repeat (5) @(negedge clk);
      en = 1'b1;
      repeat (5) @(negedge clk);
      {sdat, sclk, slat} = 3'b000;
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(negedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: got=hang expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      clear_exp();
      repeat (5) @(negedge clk);
      // R13: reset state
      check_fields("R13 reset fields");
      check_act("R13 reset active", 1'b0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R8: first preset
      power_up(3'b100);
      clear_exp(); e_main = 11'd21; e_swal = 5'd9; e_ref = 9'd3;
      check_fields("R8 preset A");
      check_act("R11 active high", 1'b1);

      // R2: main register
      send_frame(2'b00, {11'h5A5, 3'b000, 1'b1, 1'b0}, 0);
      check_fields("R2 main write");
      // R3: alias address
      send_frame(2'b11, {11'h2B3, 3'b000, 1'b0, 1'b0}, 0);
      check_fields("R3 alias write");
      // R4 and R7: divider register, main untouched
      send_frame(2'b01, {5'h15, 9'h1A7, 1'b0, 1'b1}, 0);
      check_fields("R4 divider write");
      check({23'd0, main_div}, {23'd0, main_div}, {23'd0, 11'h2B3});
      // R7 explicit check of isolation at ports
      @(negedge clk);
      check("R7 main kept", {23'd0, main_div}, {23'd0, 11'h2B3});
      // R5: test register
      send_frame(2'b10, {3'd5, 3'd7, 8'h00, 1'b1, 1'b0}, 0);
      check_fields("R5 test write");
      // R6: illegal codes forced to zero
      send_frame(2'b10, {3'd3, 3'd4, 8'h00, 1'b0, 1'b0}, 0);
      check_fields("R6 illegal codes");
      send_frame(2'b10, {3'd4, 3'd3, 8'h00, 1'b1, 1'b0}, 0);
      check_fields("R6 illegal codes swapped");
      // R1: extra leading bits discarded
      send_frame(2'b01, {5'h0B, 9'h0F3, 1'b0, 1'b0}, 5);
      check_fields("R1 leading bits dropped");

      // R12: clocking without latch changes nothing
      for (int i = 0; i < 18; i++) send_bit(1'b1);
      repeat (6) @(negedge clk);
      check_fields("R12 no latch no change");

      // R11: power-save holds contents
      @(negedge clk); en = 1'b0;
      repeat (8) @(negedge clk);
      check_act("R11 active low", 1'b0);
      check_fields("R11 fields held in save");

      // R9: second preset
      power_up(3'b110);
      clear_exp(); e_main = 11'd50; e_swal = 5'd11; e_ref = 9'd5;
      check_fields("R9 preset B");

      // R10: other strap clears
      send_frame(2'b10, {3'd6, 3'd2, 8'h00, 1'b1, 1'b0}, 0);
      power_up(3'b010);
      clear_exp();
      check_fields("R10 other strap");
      send_frame(2'b00, {11'h7FF, 3'b000, 1'b1, 1'b0}, 0);
      power_up(3'b000);
      clear_exp();
      check_fields("R10 reserved strap");

      // random frames, R1 window and per-address layouts
      for (int k = 0; k < 40; k++) begin
         logic [1:0] a;
         logic [15:0] d;
         a = 2'($urandom_range(0, 3));
         d = 16'($urandom);
         send_frame(a, d, int'($urandom_range(0, 3)));
         check_fields("R1 random frame");
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule